// File: doc/BRIEF.md
# Indexed Interrupt Status Controller

This block gathers the three event sources of a mixed-signal peripheral into interrupt lines. The sources are an output event, an inverted-output event and an output-ready event. Each line has a raw flag register and an enable mask, and the two together give a masked view. The line also has a write-one set port, a write-one clear port, a mode field and an index register. The index register names the most urgent enabled source, and reading it also services that source.

Two lines are built by default. Line 0 drives the processor interrupt request. Line 1 works as an event-generator line whose consumer returns a hardware acknowledge. Both lines see the same single-cycle source pulses, and each keeps its own flags. A register bus with separate write and read strobes reaches every register. A debug qualifier on a read turns off the read's side effect.

Top module: `irq_index_ctrl`

## Requirements
- R1: After reset, the following read as 0 on every line: raw flags, mask, masked view and index. Each `irq_req` bit is low. The mode field reads 1 on line 0 and 2 on line 1.
- R2: A one-cycle pulse on `src_pulse[0]`, `[1]` or `[2]` sets raw flag bit 1, 2 or 3 of every line. Bit 0 and bits above 3 always read 0.
- R3: A write to the set register sets each raw bit whose data bit is 1. Raw bits whose data bit is 0 are left unchanged.
- R4: A write to the clear register clears each raw bit whose data bit is 1, whether or not that source is masked. Data bits that are 0 have no effect. A source pulse in the same cycle as a clear of its bit leaves the bit set.
- R5: The masked view is the raw flags ANDed with the mask, using bits 1 to 3. `irq_req[n]` is high while line n's masked view is nonzero and its mode is 1 or 2.
- R6: The index register (bits 2:0) reads 0 when nothing is masked and pending. Otherwise it reads 2, 3 or 4 for raw bit 1, 2 or 3, choosing the lowest such bit. Masked-off sources are never reported.
- R7: A non-debug read of the index register clears the raw bit it reports, one clock after the read. The next read then reports the next pending source, and reads 0 once all pending sources are serviced.
- R8: A read with `bus_dbg` high changes no raw flag, on any register.
- R9: In mode 2, a pulse on `hw_ack[n]` clears the raw bit that line n's index reports. In mode 1, `hw_ack[n]` has no effect.
- R10: In mode 0, and in the unused code 3, the line's `irq_req` is held low. Flags are still recorded, so the request returns once the mode is set back to 1.
- R11: Each line keeps its own mask, raw flags and mode. A write or index read on one line leaves the other line unchanged.
- R12: Address decoding works as follows. `bus_addr[4]` selects the line. `bus_addr[3]` must be 0. `bus_addr[2:0]` selects the register: 0 index, 1 mask, 2 raw, 3 masked, 4 set, 5 clear, 6 mode. The set and clear registers, code 7, and any address with bit 3 set all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for read side effects) |
| bus_dbg | input | 1 | Marks a read as a debug access without side effects |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| src_pulse | input | 3 | Single-cycle events: output, inverted output, output ready |
| hw_ack | input | 2 | Per-line acknowledge from the hardware consumer |
| irq_req | output | 2 | Per-line interrupt or event request |

## Verification
The assertions are checked on every cycle, next to the flag logic. They cover these effects on the raw flags one cycle later: set writes, clear writes, servicing index reads and debug reads. They also check that a nonzero index always points at a single masked, pending source. The bench scenarios cover the rest. These include the numeric index order as sources are serviced one by one, and the mask excluding a pending source. They also include the clear-versus-event collision, the acknowledge behaving differently in each mode, the request being suppressed in disabled mode, and the independence of the two lines. These effects show only through sequences of bus accesses.

// File: rtl/irq_idx_pkg.sv
package irq_idx_pkg;

    localparam int NUM_SRC   = 3;
    localparam int SRC_LSB   = 1;
    localparam int IDX_W     = 3;
    localparam int DATA_W    = 32;
    localparam int REG_SEL_W = 3;
    localparam int MODE_W    = 2;

    typedef enum logic [REG_SEL_W-1:0] {
        REG_INDEX  = 3'd0,
        REG_MASK   = 3'd1,
        REG_RAW    = 3'd2,
        REG_MASKED = 3'd3,
        REG_SET    = 3'd4,
        REG_CLEAR  = 3'd5,
        REG_MODE   = 3'd6,
        REG_NONE   = 3'd7
    } reg_sel_e;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF = 2'd0,
        MODE_SW  = 2'd1,
        MODE_HW  = 2'd2,
        MODE_RSV = 2'd3
    } line_mode_e;

    typedef struct packed {
        logic               wr;
        logic               rd;
        logic               dbg;
        reg_sel_e           sel;
        logic [NUM_SRC-1:0] flags;
        logic [MODE_W-1:0]  mode;
    } bank_req_t;

    // index code reported for source slot i (slot 0 sits at bit SRC_LSB)
    function automatic logic [IDX_W-1:0] slot_to_index(input int slot);
        return IDX_W'(slot + SRC_LSB + 1);
    endfunction

    function automatic logic mode_drives(input line_mode_e m);
        return (m == MODE_SW) || (m == MODE_HW);
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_idx_pkg::*;
#(
    parameter int NUM_LINES = 2,
    parameter int ADDR_W    = 5,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic                 bus_dbg,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [LINE_W-1:0]    line_sel,
    output bank_req_t            req_out [NUM_LINES]
);

    reg_sel_e sel;

    always_comb begin
        if (bus_addr[REG_SEL_W])
            sel = REG_NONE;
        else
            sel = reg_sel_e'(bus_addr[REG_SEL_W-1:0]);
        line_sel = bus_addr[REG_SEL_W+1 +: LINE_W];
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_req
        logic hit;
        assign hit = (line_sel == LINE_W'(g));
        always_comb begin
            req_out[g].wr    = bus_wr & hit;
            req_out[g].rd    = bus_rd & hit;
            req_out[g].dbg   = bus_dbg;
            req_out[g].sel   = sel;
            req_out[g].flags = bus_wdata[SRC_LSB +: NUM_SRC];
            req_out[g].mode  = bus_wdata[MODE_W-1:0];
        end
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_idx_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0]     pend,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     grant
);

    // scan from the top down so the lowest pending slot wins
    always_comb begin
        idx   = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx      = slot_to_index(i);
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_line_bank.sv
module irq_line_bank
    import irq_idx_pkg::*;
#(
    parameter line_mode_e MODE_RST = MODE_SW
) (
    input  logic               clk,
    input  logic               rst,
    input  bank_req_t          req,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic               hw_ack,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq
);

    logic [NUM_SRC-1:0] raw_q, raw_d;
    logic [NUM_SRC-1:0] mask_q;
    line_mode_e         mode_q;

    logic [NUM_SRC-1:0] masked;
    logic [NUM_SRC-1:0] set_bits, clr_bits, rd_clr, ack_clr, grant;
    logic [IDX_W-1:0]   idx;

    assign masked = raw_q & mask_q;

    irq_prio_enc #(.N(NUM_SRC)) u_prio (
        .pend  (masked),
        .idx   (idx),
        .grant (grant)
    );

    always_comb begin
        set_bits = (req.wr && req.sel == REG_SET)   ? req.flags : '0;
        clr_bits = (req.wr && req.sel == REG_CLEAR) ? req.flags : '0;
        rd_clr   = (req.rd && !req.dbg && req.sel == REG_INDEX) ? grant : '0;
        ack_clr  = (hw_ack && mode_q == MODE_HW) ? grant : '0;
        // a source event wins over any clear in the same cycle
        raw_d    = (raw_q & ~(clr_bits | rd_clr | ack_clr)) | set_bits | src_pulse;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
            mode_q <= MODE_RST;
        end else begin
            raw_q <= raw_d;
            if (req.wr && req.sel == REG_MASK)
                mask_q <= req.flags;
            if (req.wr && req.sel == REG_MODE)
                mode_q <= line_mode_e'(req.mode);
        end
    end

    assign irq = (|masked) && mode_drives(mode_q);

    always_comb begin
        rdata = '0;
        case (req.sel)
            REG_INDEX:  rdata[IDX_W-1:0]          = idx;
            REG_MASK:   rdata[SRC_LSB +: NUM_SRC] = mask_q;
            REG_RAW:    rdata[SRC_LSB +: NUM_SRC] = raw_q;
            REG_MASKED: rdata[SRC_LSB +: NUM_SRC] = masked;
            REG_MODE:   rdata[MODE_W-1:0]         = mode_q;
            default:    rdata                     = '0;
        endcase
    end

    // R3: every bit written to the set port is present one cycle later
    p_set_takes_r3: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == REG_SET)
        |=> ((raw_q & $past(req.flags)) == $past(req.flags)));

    // R4: a cleared bit is gone next cycle unless its source fired together with the clear
    p_clear_takes_r4: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == REG_CLEAR)
        |=> ((raw_q & $past(req.flags & ~src_pulse)) == '0));

    // R7: a servicing index read removes the granted flag
    p_read_services_r7: assert property (@(posedge clk) disable iff (rst)
        (req.rd && !req.dbg && req.sel == REG_INDEX && (|grant))
        |=> ((raw_q & $past(grant & ~src_pulse)) == '0));

    // R8: a debug read without a write or acknowledge loses no flag
    p_debug_read_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.dbg && !req.wr && !hw_ack)
        |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

    // R6: a nonzero index points at exactly one masked, pending source
    p_index_valid_r6: assert property (@(posedge clk) disable iff (rst)
        (idx != '0) |-> ($onehot(grant) && ((grant & ~masked) == '0)));

endmodule

// File: rtl/irq_index_ctrl.sv
module irq_index_ctrl
    import irq_idx_pkg::*;
#(
    parameter int NUM_LINES = 2,
    parameter int ADDR_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic                 bus_dbg,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_SRC-1:0]   src_pulse,
    input  logic [NUM_LINES-1:0] hw_ack,
    output logic [NUM_LINES-1:0] irq_req
);

    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    bank_req_t          reqs [NUM_LINES];
    logic [DATA_W-1:0]  line_rdata [NUM_LINES];
    logic [LINE_W-1:0]  line_sel;

    irq_bus_decode #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_decode (
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_dbg   (bus_dbg),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .line_sel  (line_sel),
        .req_out   (reqs)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam line_mode_e RST_MODE = (g == 0) ? MODE_SW : MODE_HW;
        irq_line_bank #(.MODE_RST(RST_MODE)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .req       (reqs[g]),
            .src_pulse (src_pulse),
            .hw_ack    (hw_ack[g]),
            .rdata     (line_rdata[g]),
            .irq       (irq_req[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_LINES; i++)
            if (line_sel == LINE_W'(i))
                bus_rdata = line_rdata[i];
    end

endmodule

// File: tb/irq_index_ctrl_bench.sv
module irq_index_ctrl_bench;
    import irq_idx_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_dbg = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  src_pulse = '0;
    logic [1:0]  hw_ack = '0;
    logic [1:0]  irq_req;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    irq_index_ctrl u_irq_index_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_dbg(bus_dbg),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_pulse(src_pulse), .hw_ack(hw_ack), .irq_req(irq_req)
    );

    // register codes from R12
    localparam logic [2:0] A_IDX = 3'd0, A_MSK = 3'd1, A_RAW = 3'd2, A_MSD = 3'd3,
                           A_SET = 3'd4, A_CLR = 3'd5, A_MOD = 3'd6;

    function automatic logic [4:0] ad(input int line, input logic [2:0] r);
        return {line[0], 1'b0, r};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, input logic dbg, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; bus_dbg = dbg;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_dbg = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic dbg,
                          input logic [31:0] exp);
        logic [31:0] d;
        rd(a, dbg, d);
        check(req, d, exp);
    endtask

    task automatic pulse_src(input logic [2:0] b);
        @(negedge clk); src_pulse = b;
        @(negedge clk); src_pulse = '0;
    endtask

    task automatic wipe;
        wr(ad(0, A_CLR), 32'hE);
        wr(ad(1, A_CLR), 32'hE);
        wr(ad(0, A_MSK), 32'h0);
        wr(ad(1, A_MSK), 32'h0);
    endtask

    task automatic t_reset;
        rd_chk("R1 raw0",  ad(0, A_RAW), 1'b1, 32'h0);
        rd_chk("R1 mask0", ad(0, A_MSK), 1'b1, 32'h0);
        rd_chk("R1 idx0",  ad(0, A_IDX), 1'b1, 32'h0);
        rd_chk("R1 mode0", ad(0, A_MOD), 1'b1, 32'h1);
        rd_chk("R1 mode1", ad(1, A_MOD), 1'b1, 32'h2);
        check("R1 irq", {30'b0, irq_req}, 32'h0);
    endtask

    task automatic t_sources;
        pulse_src(3'b001);
        rd_chk("R2 out event", ad(0, A_RAW), 1'b1, 32'h2);
        pulse_src(3'b010);
        rd_chk("R2 inverted event", ad(0, A_RAW), 1'b1, 32'h6);
        pulse_src(3'b100);
        rd_chk("R2 ready event", ad(0, A_RAW), 1'b1, 32'hE);
        rd_chk("R11 line1 sees sources", ad(1, A_RAW), 1'b1, 32'hE);
    endtask

    task automatic t_clear;
        wr(ad(0, A_CLR), 32'h4);
        rd_chk("R4 clear masked-off bit", ad(0, A_RAW), 1'b1, 32'hA);
        wr(ad(0, A_CLR), 32'h0);
        rd_chk("R4 zero write no effect", ad(0, A_RAW), 1'b1, 32'hA);
        rd_chk("R11 line1 untouched", ad(1, A_RAW), 1'b1, 32'hE);
    endtask

    task automatic t_set;
        wipe();
        wr(ad(0, A_SET), 32'h8);
        rd_chk("R3 set bit3", ad(0, A_RAW), 1'b1, 32'h8);
        wr(ad(0, A_SET), 32'h0);
        rd_chk("R3 zero write no effect", ad(0, A_RAW), 1'b1, 32'h8);
        rd_chk("R12 set reg reads 0", ad(0, A_SET), 1'b1, 32'h0);
        rd_chk("R12 clear reg reads 0", ad(0, A_CLR), 1'b1, 32'h0);
        rd_chk("R12 bit3 address reads 0", 5'b01010, 1'b1, 32'h0);
    endtask

    task automatic t_mask;
        wr(ad(1, A_SET), 32'hE);
        check("R5 irq low while masked", {30'b0, irq_req}, 32'h0);
        wr(ad(0, A_MSK), 32'hA);
        rd_chk("R5 masked view", ad(0, A_MSD), 1'b1, 32'h8);
        check("R5 irq0 high", {31'b0, irq_req[0]}, 32'h1);
        check("R11 irq1 stays low", {31'b0, irq_req[1]}, 32'h0);
        wr(ad(0, A_MSK), 32'h0);
        check("R5 irq0 low after mask off", {31'b0, irq_req[0]}, 32'h0);
    endtask

    task automatic t_index;
        wipe();
        wr(ad(0, A_SET), 32'hE);
        wr(ad(0, A_MSK), 32'hE);
        rd_chk("R6 debug idx", ad(0, A_IDX), 1'b1, 32'h2);
        rd_chk("R8 debug idx again", ad(0, A_IDX), 1'b1, 32'h2);
        rd_chk("R8 raw kept", ad(0, A_RAW), 1'b1, 32'hE);
        rd_chk("R7 first service", ad(0, A_IDX), 1'b0, 32'h2);
        rd_chk("R7 second service", ad(0, A_IDX), 1'b0, 32'h3);
        rd_chk("R7 third service", ad(0, A_IDX), 1'b0, 32'h4);
        rd_chk("R7 none left", ad(0, A_IDX), 1'b0, 32'h0);
        rd_chk("R7 raw empty", ad(0, A_RAW), 1'b1, 32'h0);
        wr(ad(0, A_SET), 32'hE);
        wr(ad(0, A_MSK), 32'hC);
        rd_chk("R6 masked source skipped", ad(0, A_IDX), 1'b1, 32'h3);
        wr(ad(0, A_MSK), 32'h8);
        rd_chk("R6 only ready", ad(0, A_IDX), 1'b1, 32'h4);
    endtask

    task automatic t_collision;
        wipe();
        @(negedge clk);
        bus_addr = ad(0, A_CLR); bus_wdata = 32'h2; bus_wr = 1'b1; src_pulse = 3'b001;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; src_pulse = '0;
        rd_chk("R4 event beats clear", ad(0, A_RAW), 1'b1, 32'h2);
    endtask

    task automatic t_ack;
        wipe();
        wr(ad(1, A_SET), 32'h6);
        wr(ad(1, A_MSK), 32'h6);
        @(negedge clk); hw_ack = 2'b10;
        @(negedge clk); hw_ack = 2'b00;
        rd_chk("R9 hw mode ack clears top", ad(1, A_RAW), 1'b1, 32'h4);
        wr(ad(0, A_SET), 32'h2);
        wr(ad(0, A_MSK), 32'h2);
        @(negedge clk); hw_ack = 2'b01;
        @(negedge clk); hw_ack = 2'b00;
        rd_chk("R9 sw mode ack ignored", ad(0, A_RAW), 1'b1, 32'h2);
    endtask

    task automatic t_mode_off;
        wipe();
        wr(ad(0, A_MSK), 32'h2);
        wr(ad(0, A_MOD), 32'h0);
        pulse_src(3'b001);
        check("R10 irq held low", {31'b0, irq_req[0]}, 32'h0);
        rd_chk("R10 flag recorded", ad(0, A_RAW), 1'b1, 32'h2);
        wr(ad(0, A_MOD), 32'h3);
        check("R10 code 3 low", {31'b0, irq_req[0]}, 32'h0);
        wr(ad(0, A_MOD), 32'h1);
        check("R10 irq back in mode 1", {31'b0, irq_req[0]}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sources();
        t_clear();
        t_set();
        t_mask();
        t_index();
        t_collision();
        t_ack();
        t_mode_off();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule